// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block fetches the operand of an 8-bit CPU instruction from a 16-bit byte-addressed space. A controller pulses `start_i` with a mode code and the current X and Y index values. The sequencer then issues one read per clock to a synchronous byte memory, whose data comes back one cycle after the address. Whenever it takes a byte from the instruction stream it asserts `pc_inc_o`, and the program-counter owner increments `pc_i` at that edge. When the operand byte has arrived, it pulses `done_o` for one cycle with the byte on `operand_o`.

The number of cycles depends on the mode. It also depends on whether an indexed sum carries out of the low address byte: only a real carry costs the extra high-byte correction cycle. Zero-page indexing and pointer fetches wrap inside page 0. Mode codes outside the defined set end the sequence after the first instruction-stream read and flag an error.

Top module: `operand_fetch_seq`

## Requirements
- R1: While reset is held low and in the first idle cycle after it, `done_o`, `mode_err_o` and `pc_inc_o` are 0.
- R2: After an accepted start, the first read is at `pc_i` with `pc_inc_o` high. Mode code 0 (immediate) returns that byte as the operand, with `done_o` high 3 edges after the edge that samples the start.
- R3: Mode codes 1 (zero page), 2 (zero page plus X) and 3 (zero page plus Y) read the operand at {0x00, byte + index mod 256}, where the index is 0, X or Y. Latency is 5 edges.
- R4: Mode code 4 (absolute) takes a low byte and then a high byte from consecutive PC reads, advancing PC by 2 in total, and reads the operand at {high, low}. Latency is 6 edges.
- R5: Mode codes 5 (absolute plus X) and 6 (absolute plus Y) add the index to the low byte. Without a carry the latency is 6 edges. A carry costs one extra edge, which increments the high byte, with 0xFF wrapping to 0x00.
- R6: Mode code 7 (pre-indexed indirect) forms pointer = byte + X mod 256, reads the address low byte at {0x00, pointer} and the high byte at {0x00, pointer+1 mod 256}, then reads the operand there. Latency is 8 edges.
- R7: Mode code 8 (post-indexed indirect) reads a base from {0x00, byte} and {0x00, byte+1 mod 256}, adds Y with the same carry rule as R5, and reads the operand. Latency is 8 edges, or 9 on a carry.
- R8: `done_o` is high for exactly one cycle per sequence, and `operand_o` is valid in that cycle.
- R9: The mode, X and Y values are sampled only with an accepted start. A start request, or any change of mode, X or Y, while a sequence runs has no effect on the result or on the number of PC increments.
- R10: Mode codes 9 to 15 end after the first PC read, with latency 3 and PC advanced by 1. The operand is the fetched byte and `mode_err_o` is high in the `done_o` cycle. `mode_err_o` is never high outside a `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| mode_i | input | 4 | Addressing mode code |
| idx_x_i | input | 8 | X index value |
| idx_y_i | input | 8 | Y index value |
| pc_i | input | 16 | Current program counter |
| rd_data_i | input | 8 | Read data, one cycle after the address |
| mem_addr_o | output | 16 | Memory read address |
| pc_inc_o | output | 1 | PC increment strobe |
| done_o | output | 1 | Operand ready pulse |
| operand_o | output | 8 | Fetched operand |
| mode_err_o | output | 1 | Invalid mode code flag, with done_o |

## Verification
The bench sweeps every mode code against every X value and, through an odd multiplier, every Y value. It does so at three PC values chosen so that a base high byte of 0xFF and a zero-page pointer of 0xFF both occur. The sweep therefore hits low-byte carries, high-byte wraparound and pointer+1 wrapping inside page 0. A design that always paid the correction cycle, or never paid it, shows a wrong latency. One that let pointer+1 cross into page 1 returns a wrong operand. Each run also raises a junk start with altered mode and indices one cycle into the sequence, and a design that restarted or resampled would show extra PC increments or a wrong operand.

// File: rtl/opf_pkg.sv
// Package: shared types for the operand fetch sequencer.
// Assumes mode codes above the last defined one are invalid.
package opf_pkg;

    localparam int MODE_W = 4;

    // Addressing mode codes; the numeric values are the external encoding.
    typedef enum logic [MODE_W-1:0] {
        AM_IMM  = 4'd0,
        AM_ZP   = 4'd1,
        AM_ZPX  = 4'd2,
        AM_ZPY  = 4'd3,
        AM_ABS  = 4'd4,
        AM_ABSX = 4'd5,
        AM_ABSY = 4'd6,
        AM_INDX = 4'd7,
        AM_INDY = 4'd8
    } amode_e;

    // Sequencer states; each state issues at most one memory read.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PC0,
        ST_PC1,
        ST_ZPL,
        ST_PTRL,
        ST_PTRH,
        ST_ADRH,
        ST_FIX,
        ST_RDOP,
        ST_FIN
    } seq_st_e;

    // True when the code names a defined addressing mode.
    function automatic logic mode_is_valid(input logic [MODE_W-1:0] m);
        return m <= AM_INDY;
    endfunction

endpackage

// File: rtl/opf_ctrl.sv
// Module: opf_ctrl
// Sequencing FSM. Accepts a start only in idle, latches the mode and
// walks the per-mode state chain. Assumes carry_i is meaningful only in
// ST_ADRH, where it selects the high-byte correction cycle.
module opf_ctrl
    import opf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              carry_i,
    output seq_st_e           state_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              accept_o,
    output logic              bad_o
);

    seq_st_e           state_q;
    seq_st_e           state_d;
    logic [MODE_W-1:0] mode_q;
    logic              bad_q;

    assign accept_o = (state_q == ST_IDLE) && start_i;

    // Next-state selection per mode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_PC0;
            ST_PC0: begin
                if (bad_q) begin
                    state_d = ST_FIN;
                end else begin
                    case (mode_q)
                        AM_IMM:                           state_d = ST_FIN;
                        AM_ABS, AM_ABSX, AM_ABSY:         state_d = ST_PC1;
                        default:                          state_d = ST_ZPL;
                    endcase
                end
            end
            ST_ZPL:  state_d = (mode_q == AM_INDX || mode_q == AM_INDY) ? ST_PTRL : ST_RDOP;
            ST_PTRL: state_d = ST_PTRH;
            ST_PTRH: state_d = ST_ADRH;
            ST_PC1:  state_d = ST_ADRH;
            ST_ADRH: state_d = carry_i ? ST_FIX : ST_RDOP;
            ST_FIX:  state_d = ST_RDOP;
            ST_RDOP: state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, mode and invalid-code registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                mode_q <= mode_i;
                bad_q  <= !mode_is_valid(mode_i);
            end
        end
    end

    assign state_o = state_q;
    assign mode_o  = mode_q;
    assign bad_o   = bad_q;

endmodule

// File: rtl/opf_addr.sv
// Module: opf_addr
// Address datapath. Latches the index values at start, keeps the working
// address and the captured low byte, and owns the single index adder
// shared by zero-page indexing and low-byte indexing. Assumes read data
// arrives one cycle after the address was driven.
module opf_addr
    import opf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_st_e           state_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              accept_i,
    input  logic [DATA_W-1:0] idx_x_i,
    input  logic [DATA_W-1:0] idx_y_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              pc_inc_o,
    output logic              carry_o
);

    localparam int PW = ADDR_W - DATA_W;

    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] y_q;
    logic [DATA_W-1:0] lo_q;
    logic [ADDR_W-1:0] adr_q;
    logic [DATA_W-1:0] idx;
    logic [DATA_W-1:0] add_a;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] ptr_next;

    // Index selection for the shared adder
    always_comb begin
        idx = '0;
        if (state_i == ST_ZPL) begin
            if (mode_i == AM_ZPX || mode_i == AM_INDX) idx = x_q;
            else if (mode_i == AM_ZPY)                 idx = y_q;
        end else if (state_i == ST_ADRH) begin
            if (mode_i == AM_ABSX)                         idx = x_q;
            else if (mode_i == AM_ABSY || mode_i == AM_INDY) idx = y_q;
        end
    end

    // Shared low-byte adder with carry out
    always_comb begin
        add_a = (state_i == ST_ZPL) ? rd_data_i : lo_q;
        sum   = {1'b0, add_a} + {1'b0, idx};
    end

    assign carry_o  = sum[DATA_W];
    assign ptr_next = adr_q[DATA_W-1:0] + {{(DATA_W-1){1'b0}}, 1'b1};

    // Index latches and working address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            lo_q  <= '0;
            adr_q <= '0;
        end else begin
            if (accept_i) begin
                x_q <= idx_x_i;
                y_q <= idx_y_i;
            end
            case (state_i)
                ST_ZPL:          adr_q <= {{PW{1'b0}}, sum[DATA_W-1:0]};
                ST_PC1, ST_PTRH: lo_q  <= rd_data_i;
                ST_ADRH:         adr_q <= {rd_data_i, sum[DATA_W-1:0]};
                ST_FIX:          adr_q[ADDR_W-1:DATA_W] <= adr_q[ADDR_W-1:DATA_W]
                                                          + {{(PW-1){1'b0}}, 1'b1};
                default: ;
            endcase
        end
    end

    // Read address and PC strobe per state
    always_comb begin
        pc_inc_o   = 1'b0;
        mem_addr_o = pc_i;
        case (state_i)
            ST_PC0, ST_PC1: pc_inc_o = 1'b1;
            ST_PTRL:        mem_addr_o = {{PW{1'b0}}, adr_q[DATA_W-1:0]};
            ST_PTRH:        mem_addr_o = {{PW{1'b0}}, ptr_next};
            ST_RDOP:        mem_addr_o = adr_q;
            default: ;
        endcase
    end

endmodule

// File: rtl/opf_result.sv
// Module: opf_result
// Result stage. Captures the final read byte in the finishing state and
// raises a one-cycle done pulse with the error flag alongside it.
// Assumes fin_i is high for exactly one cycle per sequence.
module opf_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_i,
    input  logic              bad_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] operand_o,
    output logic              done_o,
    output logic              err_o
);

    // Operand capture and done/error pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            operand_o <= '0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            done_o <= fin_i;
            err_o  <= fin_i && bad_i;
            if (fin_i) operand_o <= rd_data_i;
        end
    end

endmodule

// File: rtl/operand_fetch_seq.sv
// Module: operand_fetch_seq
// Operand fetch sequencer top. Wires the control FSM, the address
// datapath and the result stage. Assumes a synchronous memory with one
// cycle of read latency and a PC owner that increments on pc_inc_o.
module operand_fetch_seq
    import opf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DATA_W-1:0] idx_x_i,
    input  logic [DATA_W-1:0] idx_y_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              pc_inc_o,
    output logic              done_o,
    output logic [DATA_W-1:0] operand_o,
    output logic              mode_err_o
);

    seq_st_e           state_w;
    logic [MODE_W-1:0] mode_w;
    logic              accept_w;
    logic              bad_w;
    logic              carry_w;

    opf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .mode_i   (mode_i),
        .carry_i  (carry_w),
        .state_o  (state_w),
        .mode_o   (mode_w),
        .accept_o (accept_w),
        .bad_o    (bad_w)
    );

    opf_addr #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state_w),
        .mode_i     (mode_w),
        .accept_i   (accept_w),
        .idx_x_i    (idx_x_i),
        .idx_y_i    (idx_y_i),
        .pc_i       (pc_i),
        .rd_data_i  (rd_data_i),
        .mem_addr_o (mem_addr_o),
        .pc_inc_o   (pc_inc_o),
        .carry_o    (carry_w)
    );

    opf_result #(
        .DATA_W (DATA_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin_i     (state_w == ST_FIN),
        .bad_i     (bad_w),
        .rd_data_i (rd_data_i),
        .operand_o (operand_o),
        .done_o    (done_o),
        .err_o     (mode_err_o)
    );

endmodule

// File: rtl/operand_fetch_seq_chk.sv
// Module: operand_fetch_seq_chk
// Property checker for the operand fetch sequencer, bound to the top.
// Assumes the state input is the control FSM's current state.
module operand_fetch_seq_chk
    import opf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              pc_inc_o,
    input logic              done_o,
    input logic              mode_err_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input seq_st_e           state_i
);

    AST_ACCEPT_FETCHES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE && start_i) |=> pc_inc_o); // R2

    AST_PC_INC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc_o && $past(pc_inc_o)) |=> !pc_inc_o); // R4

    AST_PTR_HI_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_PTRH) |-> (mem_addr_o[ADDR_W-1:DATA_W] == '0 &&
            mem_addr_o[DATA_W-1:0] == DATA_W'($past(mem_addr_o[DATA_W-1:0]) + 1'b1))); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_IDLE && start_i) |=> (state_i != ST_PC0)); // R9

    AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> done_o); // R10

endmodule

bind operand_fetch_seq operand_fetch_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .pc_inc_o   (pc_inc_o),
    .done_o     (done_o),
    .mode_err_o (mode_err_o),
    .mem_addr_o (mem_addr_o),
    .state_i    (state_w)
);

// File: tb/operand_fetch_seq_tb_top.sv
// Bench: sweeps all mode codes against all X/Y values at three PCs, with
// a computed memory image and arithmetically derived expectations.
module operand_fetch_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [7:0]  x_i = '0;
    logic [7:0]  y_i = '0;
    logic [15:0] pc_q;
    logic [7:0]  rd_q;
    logic        pc_load = 1'b1;
    logic [15:0] pc_new = '0;
    logic [15:0] mem_addr_o;
    logic        pc_inc_o;
    logic        done_o;
    logic [7:0]  operand_o;
    logic        mode_err_o;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    operand_fetch_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .idx_x_i    (x_i),
        .idx_y_i    (y_i),
        .pc_i       (pc_q),
        .rd_data_i  (rd_q),
        .mem_addr_o (mem_addr_o),
        .pc_inc_o   (pc_inc_o),
        .done_o     (done_o),
        .operand_o  (operand_o),
        .mode_err_o (mode_err_o)
    );

    // Memory image as a function of the address
    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] t;
        t = a[7:0] + a[15:8] * 8'd13;
        return t ^ 8'h3C;
    endfunction

    // PC owner and one-cycle-latency memory model
    always @(posedge clk) begin
        if (pc_load)       pc_q <= pc_new;
        else if (pc_inc_o) pc_q <= pc_q + 16'd1;
        rd_q <= memf(mem_addr_o);
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] m, input logic [15:0] pc,
                       input logic [7:0] x, input logic [7:0] y);
        logic [7:0]  b1;
        logic [7:0]  p8;
        logic [15:0] base;
        logic [15:0] ea;
        logic [7:0]  exp_op;
        int          exp_lat;
        int          exp_adv;
        logic        exp_err;
        string       tag;
        int          lat;
        b1 = memf(pc);
        ea = '0; exp_op = '0; exp_adv = 1; exp_err = 1'b0;
        case (m)
            4'd0: begin tag = "R2"; exp_lat = 3; end
            4'd1: begin tag = "R3"; exp_lat = 5; ea = {8'h00, b1}; end
            4'd2: begin tag = "R3"; exp_lat = 5; p8 = b1 + x; ea = {8'h00, p8}; end
            4'd3: begin tag = "R3"; exp_lat = 5; p8 = b1 + y; ea = {8'h00, p8}; end
            4'd4: begin tag = "R4"; exp_lat = 6; exp_adv = 2; ea = {memf(pc + 16'd1), b1}; end
            4'd5, 4'd6: begin
                tag = "R5"; exp_adv = 2;
                base = {memf(pc + 16'd1), b1};
                p8 = (m == 4'd5) ? x : y;
                ea = base + {8'h00, p8};
                exp_lat = ({1'b0, b1} + {1'b0, p8} > 9'd255) ? 7 : 6;
            end
            4'd7: begin
                tag = "R6"; exp_lat = 8;
                p8 = b1 + x;
                ea = {memf({8'h00, 8'(p8 + 8'd1)}), memf({8'h00, p8})};
            end
            4'd8: begin
                tag = "R7";
                base = {memf({8'h00, 8'(b1 + 8'd1)}), memf({8'h00, b1})};
                ea = base + {8'h00, y};
                exp_lat = ({1'b0, base[7:0]} + {1'b0, y} > 9'd255) ? 9 : 8;
            end
            default: begin tag = "R10"; exp_lat = 3; exp_err = 1'b1; end
        endcase
        exp_op = (m == 4'd0 || m > 4'd8) ? b1 : memf(ea);

        @(negedge clk);
        pc_load = 1'b1; pc_new = pc;
        @(negedge clk);
        pc_load = 1'b0; start_i = 1'b1; mode_i = m; x_i = x; y_i = y;
        lat = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                // R9: busy-time start with altered inputs must be ignored
                start_i = 1'b1; mode_i = m ^ 4'h3; x_i = ~x; y_i = ~y;
            end else begin
                start_i = 1'b0;
            end
            if (done_o || lat >= 40) break;
        end
        check(tag, "latency", lat, exp_lat);
        check(tag, "operand", {24'h0, operand_o}, {24'h0, exp_op});
        check(exp_err ? "R10" : tag, "error flag", {31'h0, mode_err_o}, {31'h0, exp_err});
        check("R9", "pc advance", {16'h0, 16'(pc_q - pc)}, exp_adv);
        @(negedge clk);
        check("R8", "done width", {31'h0, done_o}, 32'h0);
    endtask

    // Stimulus: reset checks, then the sweep
    initial begin
        logic [15:0] pcs [3];
        pcs[0] = 16'h00C2;
        pcs[1] = 16'h00C3;
        pcs[2] = 16'h7A10;
        repeat (3) @(negedge clk);
        check("R1", "done in reset", {31'h0, done_o}, 32'h0);
        check("R1", "err in reset", {31'h0, mode_err_o}, 32'h0);
        check("R1", "pc_inc in reset", {31'h0, pc_inc_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "pc_inc idle", {31'h0, pc_inc_o}, 32'h0);
        check("R1", "done idle", {31'h0, done_o}, 32'h0);
        for (int p = 0; p < 3; p++) begin
            for (int m = 0; m < 16; m++) begin
                for (int i = 0; i < 256; i++) begin
                    run(4'(m), pcs[p], 8'(i), 8'(i * 37 + 11));
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule